// File: doc/BRIEF.md
# I2C Slave Port with Acknowledge Control

This block is the target side of a register-driven I2C controller. It watches an open-drain SCL/SDA pair through synchronisers, recognises START and STOP, and compares the first byte of each transfer with a programmed 7-bit own address and, when enabled, with the general call address. Once addressed, it receives data bytes from the bus master or sends bytes that software supplies. Each bus event is reported as a status code with an interrupt flag. While that flag is set during a transfer, the block holds SCL low, so software can take as long as it needs.

A single acknowledge-enable input governs the whole exchange. While it is low, the block answers no address. When it is high, received bytes are acknowledged, and when it is low they are refused. If it is low at the moment a transmit byte is loaded, that byte is the final one. Software ends the flag by pulsing a clear strobe, which also moves the transfer on to its next step. A separate abort strobe drops the block back to idle as though a STOP had been seen, and it drives nothing onto the bus.

Top module: `i2c_ack_slave`

## Requirements
- R1: Each addressed-phase event (address, data byte or sent byte acknowledged or refused) sets irq_flag, and the block pulls SCL low (scl_oe=1) until flag_clr is pulsed. The block then releases SCL one cycle after loading any new SDA level.
- R2: While ack_en=0, a matching address is not acknowledged (SDA stays released in the ninth clock), status stays F8h and irq_flag stays 0.
- R3: When ack_en=1 and the address byte's upper seven bits equal own_addr, the block acknowledges. Status becomes 60h if bit 0 (read/write) is 0 and A8h if it is 1. Any other address is ignored and status stays F8h.
- R4: An address byte of 00h is acknowledged with status 70h only if gc_en=1 and ack_en=1. Data received after it reports 90h (ACKed) or 98h (NACKed).
- R5: A data byte received after own-address write is ACKed with status 80h if ack_en=1, and NACKed with status 88h if ack_en=0. rx_byte holds the byte in both cases. After 88h or 98h is cleared, status returns to F8h and the block is no longer addressed.
- R6: In read transfers, tx_byte is latched when flag_clr is pulsed and is sent MSB first. The master's ninth-bit response gives status B8h (low, ACK) or C0h (high, NACK). Clearing C0h returns status to F8h.
- R7: If ack_en=0 when a transmit byte is latched, that byte is the last one. When the master ACKs it, status becomes C8h. Clearing the flag returns status to F8h with SDA released.
- R8: A STOP, or a repeated START, while addressed in a data phase sets status A0h with irq_flag and does not stretch SCL. Clearing the flag gives F8h.
- R9: A stop_req pulse returns the block to idle in the next cycle: status F8h, irq_flag 0, SDA released, and SCL released one cycle later.
- R10: irq equals irq_flag AND irq_en. Every status change to a code other than F8h comes with irq_flag=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | 7 | Own 7-bit bus address |
| gc_en | input | 1 | Enables answering the general call address |
| ack_en | input | 1 | Acknowledge enable (respond / ACK / not-last) |
| tx_byte | input | 8 | Byte to send, latched on flag clear |
| flag_clr | input | 1 | One-cycle strobe that clears the interrupt flag |
| stop_req | input | 1 | One-cycle strobe that acts like a received STOP |
| irq_en | input | 1 | Interrupt output enable |
| rx_byte | output | 8 | Last byte received |
| status | output | 8 | Current status code |
| irq_flag | output | 1 | Interrupt flag |
| irq | output | 1 | Interrupt request |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A wrong bit count or mode in this block shows up at the ports within one byte time. The ninth-clock acknowledge level seen by the master is wrong, or the status code raised at the next ninth SCL fall is wrong. A transfer that fails to enter or leave the held state shows as SCL stuck low or never stretched. The bench sees this as a hung master, or as a bus still high after forty cycles in which it must be low. Transmit path faults show as a wrong byte assembled by the master, a wrong B8h/C0h/C8h choice, or SDA still driven after the final clear.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  localparam logic [7:0] SC_ADDR_WR  = 8'h60;
  localparam logic [7:0] SC_GCALL    = 8'h70;
  localparam logic [7:0] SC_RX_ACK   = 8'h80;
  localparam logic [7:0] SC_RX_NACK  = 8'h88;
  localparam logic [7:0] SC_GRX_ACK  = 8'h90;
  localparam logic [7:0] SC_GRX_NACK = 8'h98;
  localparam logic [7:0] SC_STOPPED  = 8'hA0;
  localparam logic [7:0] SC_ADDR_RD  = 8'hA8;
  localparam logic [7:0] SC_TX_ACK   = 8'hB8;
  localparam logic [7:0] SC_TX_NACK  = 8'hC0;
  localparam logic [7:0] SC_TX_LAST  = 8'hC8;
  localparam logic [7:0] SC_IDLE     = 8'hF8;

  typedef enum logic [2:0] {M_IDLE, M_ADDR, M_RX, M_TX, M_HOLD} mode_t;

  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [ADDR_W-1:0] own,
                                    input logic gce, input logic acken);
    return acken && ((b[7:1] == own) || (b == '0 && gce));
  endfunction

  function automatic logic [7:0] addr_code(input logic gc, input logic rd);
    return gc ? SC_GCALL : (rd ? SC_ADDR_RD : SC_ADDR_WR);
  endfunction

  function automatic logic [7:0] rx_code(input logic gc, input logic acked);
    if (gc) return acked ? SC_GRX_ACK : SC_GRX_NACK;
    return acked ? SC_RX_ACK : SC_RX_NACK;
  endfunction

  function automatic logic [7:0] tx_code(input logic m_ack, input logic last);
    if (!m_ack) return SC_TX_NACK;
    return last ? SC_TX_LAST : SC_TX_ACK;
  endfunction

  function automatic logic ends_session(input logic [7:0] code);
    return (code == SC_RX_NACK) || (code == SC_GRX_NACK) ||
           (code == SC_TX_NACK) || (code == SC_TX_LAST);
  endfunction

  function automatic logic sends_next(input logic [7:0] code);
    return (code == SC_ADDR_RD) || (code == SC_TX_ACK);
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[DEPTH-2:0], scl_i};
      sda_q <= {sda_q[DEPTH-2:0], sda_i};
    end
  end

  logic scl_now, scl_old, sda_old;
  assign scl_now  = scl_q[STAGES-1];
  assign scl_old  = scl_q[STAGES];
  assign sda_s    = sda_q[STAGES-1];
  assign sda_old  = sda_q[STAGES];

  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_s;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/i2c_slv_flag.sv
module i2c_slv_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic drop_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (drop_i) flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  assign irq_o = flag_o & en_i;

  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    drop_i |=> !flag_o); // R9
endmodule

// File: rtl/i2c_ack_slave.sv
module i2c_ack_slave
  import i2c_slv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  input  logic              ack_en,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              flag_clr,
  input  logic              stop_req,
  input  logic              irq_en,
  output logic [BYTE_W-1:0] rx_byte,
  output logic [7:0]        status,
  output logic              irq_flag,
  output logic              irq,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] BIT_ACK  = CNT_W'(BYTE_W + 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  mode_t             mode_q, nx_mode;
  logic [CNT_W-1:0]  cnt_q, nx_cnt;
  logic [BYTE_W-1:0] sh_q, nx_sh, rx_q, nx_rx;
  logic [7:0]        stat_q, nx_stat;
  logic sda_q, nx_sda, gc_q, nx_gc, rw_q, nx_rw, ackb_q, nx_ackb;
  logic last_q, nx_last, mack_q, nx_mack;
  logic ev_set, ev_clr, addressed, hit, hold_q;

  assign addressed = (mode_q == M_RX) || (mode_q == M_TX);
  assign hit       = addr_hit(sh_q, own_addr, gc_en, ack_en);

  always_comb begin
    nx_mode = mode_q;  nx_cnt = cnt_q;   nx_sh = sh_q;    nx_rx = rx_q;
    nx_stat = stat_q;  nx_sda = sda_q;   nx_gc = gc_q;    nx_rw = rw_q;
    nx_ackb = ackb_q;  nx_last = last_q; nx_mack = mack_q;
    ev_set  = 1'b0;    ev_clr = 1'b0;
    if (stop_req) begin
      nx_mode = M_IDLE; nx_sda = 1'b0; nx_stat = SC_IDLE; nx_cnt = '0;
    end else if (start_det || stop_det) begin
      if (addressed) begin
        nx_stat = SC_STOPPED; ev_set = 1'b1;
      end
      nx_mode = start_det ? M_ADDR : M_IDLE;
      nx_cnt  = '0;
      nx_sda  = 1'b0;
    end else if (scl_rise) begin
      if (mode_q inside {M_ADDR, M_RX, M_TX}) begin
        if (cnt_q < BIT_LAST && mode_q != M_TX) nx_sh = {sh_q[BYTE_W-2:0], sda_s};
        if (cnt_q == BIT_LAST && mode_q == M_TX) nx_mack = !sda_s;
        nx_cnt = cnt_q + 1'b1;
      end
    end else if (scl_fall) begin
      case (mode_q)
        M_ADDR: begin
          if (cnt_q == BIT_LAST) begin
            if (hit) begin
              nx_sda = 1'b1; nx_gc = (sh_q[7:1] == '0); nx_rw = sh_q[0];
            end else begin
              nx_mode = M_IDLE;
            end
          end else if (cnt_q == BIT_ACK) begin
            nx_sda = 1'b0; nx_stat = addr_code(gc_q, rw_q); ev_set = 1'b1;
            nx_mode = M_HOLD; nx_cnt = '0;
          end
        end
        M_RX: begin
          if (cnt_q == BIT_LAST) begin
            nx_sda = ack_en; nx_ackb = ack_en;
          end else if (cnt_q == BIT_ACK) begin
            nx_sda = 1'b0; nx_rx = sh_q; nx_stat = rx_code(gc_q, ackb_q);
            ev_set = 1'b1; nx_mode = M_HOLD; nx_cnt = '0;
          end
        end
        M_TX: begin
          if (cnt_q != '0 && cnt_q < BIT_LAST) begin
            nx_sh = {sh_q[BYTE_W-2:0], 1'b0}; nx_sda = !sh_q[BYTE_W-2];
          end else if (cnt_q == BIT_LAST) begin
            nx_sda = 1'b0;
          end else if (cnt_q == BIT_ACK) begin
            nx_stat = tx_code(mack_q, last_q); ev_set = 1'b1;
            nx_mode = M_HOLD; nx_cnt = '0;
          end
        end
        default: ;
      endcase
    end
    if (flag_clr && irq_flag && !ev_set && !stop_req) begin
      ev_clr = 1'b1;
      if (mode_q == M_HOLD) begin
        nx_cnt = '0;
        if (ends_session(stat_q)) begin
          nx_mode = M_IDLE; nx_stat = SC_IDLE;
        end else if (sends_next(stat_q)) begin
          nx_mode = M_TX; nx_sh = tx_byte; nx_sda = !tx_byte[BYTE_W-1];
          nx_last = !ack_en;
        end else begin
          nx_mode = M_RX;
        end
      end else if (stat_q == SC_STOPPED) begin
        nx_stat = SC_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_IDLE; cnt_q <= '0; sh_q <= '0; rx_q <= '0;
      stat_q <= SC_IDLE; sda_q <= 1'b0; gc_q <= 1'b0; rw_q <= 1'b0;
      ackb_q <= 1'b0; last_q <= 1'b0; mack_q <= 1'b0; hold_q <= 1'b0;
    end else begin
      mode_q <= nx_mode; cnt_q <= nx_cnt; sh_q <= nx_sh; rx_q <= nx_rx;
      stat_q <= nx_stat; sda_q <= nx_sda; gc_q <= nx_gc; rw_q <= nx_rw;
      ackb_q <= nx_ackb; last_q <= nx_last; mack_q <= nx_mack;
      hold_q <= (mode_q == M_HOLD);
    end
  end

  i2c_slv_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(ev_set), .clr_i(ev_clr),
    .drop_i(stop_req), .en_i(irq_en), .flag_o(irq_flag), .irq_o(irq));

  assign scl_oe  = hold_q;
  assign sda_oe  = sda_q;
  assign status  = stat_q;
  assign rx_byte = rx_q;

  AST_HOLD_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> $past(irq_flag)); // R1
  AST_NO_ACK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ADDR && $rose(sda_q)) |-> $past(ack_en)); // R2
  AST_RX_ACK_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RX && $rose(sda_q)) |-> $past(ack_en)); // R5
  AST_IDLE_IS_F8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_IDLE && !irq_flag) |-> stat_q == SC_IDLE); // R8
  AST_STATUS_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q != $past(stat_q) && stat_q != SC_IDLE) |-> irq_flag); // R10
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (stat_q == SC_IDLE && !sda_oe)); // R9
endmodule

// File: tb/test_i2c_ack_slave.sv
module test_i2c_ack_slave;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] own_addr = 7'h2A;
  logic gc_en = 1'b0, ack_en = 1'b1, flag_clr = 1'b0, stop_req = 1'b0, irq_en = 1'b1;
  logic [7:0] tx_byte = 8'h00;
  logic [7:0] rx_byte, status;
  logic irq_flag, irq, scl_oe, sda_oe;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_bus, sda_bus;
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  assign scl_bus = m_scl & ~scl_oe;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_ack_slave i_i2c_ack_slave (
    .clk(clk), .rst_n(rst_n), .own_addr(own_addr), .gc_en(gc_en), .ack_en(ack_en),
    .tx_byte(tx_byte), .flag_clr(flag_clr), .stop_req(stop_req), .irq_en(irq_en),
    .rx_byte(rx_byte), .status(status), .irq_flag(irq_flag), .irq(irq),
    .scl_i(scl_bus), .sda_i(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic pulse_clr();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    tick(4);
  endtask

  task automatic m_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; wait (scl_bus); tick(2*Q);
    m_sda = 1'b0; tick(2*Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic m_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; wait (scl_bus); tick(Q);
    m_sda = 1'b1; tick(2*Q);
  endtask

  // One SCL period; with do_clr the slave must still be stretching when SCL is released.
  task automatic m_bit(input logic ob, input logic do_clr, output logic ib);
    m_sda = ob; tick(Q);
    m_scl = 1'b1;
    if (do_clr) begin
      tick(40);
      chk("R1 SCL held low while flag set", scl_bus, 1'b0);
      chk("R1 flag set during stretch", irq_flag, 1'b1);
      @(negedge clk) flag_clr = 1'b1;
      @(negedge clk) flag_clr = 1'b0;
    end
    wait (scl_bus); tick(Q);
    ib = sda_bus; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, input logic clr_first, output logic acked);
    logic x;
    for (int i = 7; i >= 0; i--) m_bit(b[i], clr_first && i == 7, x);
    m_bit(1'b1, 1'b0, x);
    acked = ~x;
    tick(4);
  endtask

  task automatic rd_byte(input logic clr_first, input logic give_ack, output logic [7:0] b);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, clr_first && i == 7, x);
      b[i] = x;
    end
    m_bit(~give_ack, 1'b0, x);
    tick(4);
  endtask

  task automatic t_reset();
    chk("R9 reset status F8", status, 8'hF8);
    chk("R10 reset flag", irq_flag, 1'b0);
    chk("R1 reset scl_oe", scl_oe, 1'b0);
    chk("R9 reset sda_oe", sda_oe, 1'b0);
  endtask

  task automatic t_write();
    logic a;
    ack_en = 1'b1;
    m_start();
    wr_byte({7'h2A, 1'b0}, 1'b0, a);
    chk("R3 own write address ACKed", a, 1'b1);
    chk("R3 status 60", status, 8'h60);
    chk("R10 irq with enable", irq, 1'b1);
    chk("R1 scl_oe asserted", scl_oe, 1'b1);
    irq_en = 1'b0; tick(2);
    chk("R10 irq masked", irq, 1'b0);
    irq_en = 1'b1;
    wr_byte(8'hA5, 1'b1, a);
    chk("R5 data ACKed", a, 1'b1);
    chk("R5 status 80", status, 8'h80);
    chk("R5 rx_byte A5", rx_byte, 8'hA5);
    ack_en = 1'b0;
    wr_byte(8'h3C, 1'b1, a);
    chk("R5 data NACKed", a, 1'b0);
    chk("R5 status 88", status, 8'h88);
    chk("R5 rx_byte 3C", rx_byte, 8'h3C);
    pulse_clr();
    chk("R5 F8 after 88 clear", status, 8'hF8);
    chk("R1 SCL released after clear", scl_oe, 1'b0);
    m_stop(); tick(8);
    chk("R5 unaddressed: STOP gives no A0", status, 8'hF8);
    chk("R5 unaddressed: no flag", irq_flag, 1'b0);
    ack_en = 1'b1;
  endtask

  task automatic t_nack_addr();
    logic a;
    ack_en = 1'b0;
    m_start();
    wr_byte({7'h2A, 1'b0}, 1'b0, a);
    chk("R2 no ACK while ack_en=0", a, 1'b0);
    chk("R2 status stays F8", status, 8'hF8);
    chk("R2 no flag", irq_flag, 1'b0);
    m_stop();
    ack_en = 1'b1;
    m_start();
    wr_byte({7'h15, 1'b0}, 1'b0, a);
    chk("R3 foreign address NACKed", a, 1'b0);
    chk("R3 foreign address status F8", status, 8'hF8);
    m_stop(); tick(8);
  endtask

  task automatic t_gcall();
    logic a;
    gc_en = 1'b0;
    m_start();
    wr_byte(8'h00, 1'b0, a);
    chk("R4 general call ignored when disabled", a, 1'b0);
    chk("R4 status F8 when disabled", status, 8'hF8);
    m_stop();
    gc_en = 1'b1;
    m_start();
    wr_byte(8'h00, 1'b0, a);
    chk("R4 general call ACKed", a, 1'b1);
    chk("R4 status 70", status, 8'h70);
    wr_byte(8'h5A, 1'b1, a);
    chk("R4 status 90", status, 8'h90);
    chk("R4 rx_byte 5A", rx_byte, 8'h5A);
    ack_en = 1'b0;
    wr_byte(8'h77, 1'b1, a);
    chk("R4 general call data NACKed", a, 1'b0);
    chk("R4 status 98", status, 8'h98);
    pulse_clr();
    chk("R4 F8 after 98 clear", status, 8'hF8);
    m_stop();
    ack_en = 1'b1; gc_en = 1'b0;
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] b;
    m_start();
    wr_byte({7'h2A, 1'b1}, 1'b0, a);
    chk("R3 own read address ACKed", a, 1'b1);
    chk("R3 status A8", status, 8'hA8);
    tx_byte = 8'hC3;
    rd_byte(1'b1, 1'b1, b);
    chk("R6 first byte C3 MSB first", b, 8'hC3);
    chk("R6 status B8", status, 8'hB8);
    tx_byte = 8'h5E;
    rd_byte(1'b1, 1'b0, b);
    chk("R6 second byte 5E", b, 8'h5E);
    chk("R6 status C0", status, 8'hC0);
    pulse_clr();
    chk("R6 F8 after C0 clear", status, 8'hF8);
    m_stop(); tick(8);
  endtask

  task automatic t_last();
    logic a;
    logic [7:0] b;
    m_start();
    wr_byte({7'h2A, 1'b1}, 1'b0, a);
    chk("R7 read address status A8", status, 8'hA8);
    ack_en = 1'b0;
    tx_byte = 8'h96;
    rd_byte(1'b1, 1'b1, b);
    chk("R7 last byte 96", b, 8'h96);
    chk("R7 status C8", status, 8'hC8);
    pulse_clr();
    chk("R7 F8 after C8 clear", status, 8'hF8);
    chk("R7 SDA released", sda_oe, 1'b0);
    m_stop(); tick(8);
    chk("R7 no flag after STOP", irq_flag, 1'b0);
    ack_en = 1'b1;
  endtask

  task automatic t_stop_events();
    logic a;
    m_start();
    wr_byte({7'h2A, 1'b0}, 1'b0, a);
    chk("R8 setup status 60", status, 8'h60);
    pulse_clr();
    m_stop(); tick(8);
    chk("R8 STOP gives A0", status, 8'hA0);
    chk("R8 A0 flag", irq_flag, 1'b1);
    chk("R8 A0 no stretch", scl_oe, 1'b0);
    pulse_clr();
    chk("R8 F8 after A0 clear", status, 8'hF8);
    m_start();
    wr_byte({7'h2A, 1'b0}, 1'b0, a);
    pulse_clr();
    m_start(); tick(4);
    chk("R8 repeated START gives A0", status, 8'hA0);
    pulse_clr();
    wr_byte({7'h2A, 1'b0}, 1'b0, a);
    chk("R8 re-addressed status 60", status, 8'h60);
    @(negedge clk) stop_req = 1'b1;
    @(negedge clk) stop_req = 1'b0;
    chk("R9 abort status F8", status, 8'hF8);
    chk("R9 abort clears flag", irq_flag, 1'b0);
    chk("R9 abort releases SDA", sda_oe, 1'b0);
    tick(1);
    chk("R9 abort releases SCL", scl_oe, 1'b0);
    m_stop(); tick(8);
    chk("R9 idle after abort ignores STOP", status, 8'hF8);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired: bus transfer hung");
    summary();
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_write();
    t_nack_addr();
    t_gcall();
    t_read();
    t_last();
    t_stop_events();
    summary();
    $finish;
  end
endmodule